// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Path

This block sends bytes on one asynchronous serial line. A bus master writes a byte into a holding register. A shift register then frames the byte and sends it out bit by bit. A ready flag manages the handoff between the two registers. While the flag is high, the holding register accepts one write, and that write drops the flag. When the shift register is empty and a byte is waiting, the shift register takes the byte on the next bit-rate tick. The flag rises again on that same edge. This lets software queue the next byte while the current one is still on the line.

The handshake is strict. Any write made while the flag is low is discarded, and so is any write made while the transmitter is disabled. The external bit-rate tick sets the bit timing. A drained output shows when both registers are empty.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset, `tx_ready` is 1, `tx_drained` is 1 and `tx_line` is 1 (mark). The line stays at 1 whenever no character is being sent.
- R2: A write (`wr_en` high for one clock) is accepted when `tx_ready` is 1 and `tx_enable` is 1. `tx_ready` is 0 from the following clock on.
- R3: A write made while `tx_ready` is 0 leaves the held character and all transmitter state unchanged. That value never appears on the line.
- R4: A write made while `tx_enable` is 0 has no effect. `tx_ready` and `tx_drained` stay 1, and no character is sent later when the transmitter is enabled again.
- R5: When the shifter is empty and a character is held, the character moves to the shifter on the next clock that has `bit_tick` high. In the clock after that edge, `tx_ready` is 1 again and the line is low (start bit).
- R6: Each frame is one 0 start bit, then the 8 data bits with bit 0 first, then one 1 stop bit. Each bit lasts exactly one tick period.
- R7: If a character is waiting when a stop bit ends, its start bit follows directly, with no idle bit between frames.
- R8: Clearing `tx_enable` during a frame lets that frame complete. A held character is not moved to the shifter until `tx_enable` is 1 again. It then goes out.
- R9: `tx_drained` is 1 exactly when neither register holds a character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to queue |
| tx_enable | input | 1 | Transmitter enable |
| bit_tick | input | 1 | One-clock pulse per bit period |
| tx_ready | output | 1 | Holding register can accept a write |
| tx_line | output | 1 | Serial output, idles high |
| tx_drained | output | 1 | Holding and shift registers both empty |

## Verification
The main sweep sends all 256 byte values in one continuous burst. Each accepted write is followed at once by a second write carrying the inverted value, which lands while the flag is low. The sweep therefore separates bit-order and framing faults (every data pattern appears) from gaps between frames (back-to-back timing is measured). It also catches rejection faults, because the inverted values must never reach the line. Separate directed phases do three things:
- They write while the transmitter is disabled and idle.
- They disable the transmitter mid-frame with a second byte held, which separates "the frame completes" from "the held byte is loaded".
- They probe the ready flag on the clocks just before and just after the load edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_SEND = 1'b1
  } sh_state_e;

  localparam logic LINE_MARK  = 1'b1;
  localparam logic LINE_SPACE = 1'b0;
endpackage

// File: rtl/sertx_rst_sync.sv
module sertx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic              load,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);
  logic              accept;
  logic              full_d;
  logic [DATA_W-1:0] data_d;

  assign accept = wr_en & tx_enable & ~hold_full;

  always_comb begin
    full_d = hold_full;
    data_d = hold_data;
    if (accept) begin
      full_d = 1'b1;
      data_d = wr_data;
    end else if (load) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      hold_full <= full_d;
      if (accept) hold_data <= data_d;
    end
  end

  AST_REJECT_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold_full) |=> $stable(hold_data)); // R3
  AST_DISABLED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tx_enable && !load) |=> ($stable(hold_full) && $stable(hold_data))); // R4
  AST_ACCEPT_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_enable && !hold_full) |=> hold_full); // R2
  AST_LOAD_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !hold_full); // R5
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_enable,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              load,
  output logic              busy,
  output logic              tx_line
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  sh_state_e            state_q, state_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_W-1:0]   sr_q, sr_d;
  logic                 at_end;
  logic                 step_en;

  assign at_end  = (state_q == SH_SEND) && (idx_q == LAST_IDX);
  assign load    = bit_tick & tx_enable & hold_full & ((state_q == SH_IDLE) | at_end);
  assign step_en = bit_tick & (load | (state_q == SH_SEND));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sr_d    = sr_q;
    if (load) begin
      state_d = SH_SEND;
      idx_d   = '0;
      sr_d    = {LINE_MARK, hold_data, LINE_SPACE};
    end else if (at_end) begin
      state_d = SH_IDLE;
      idx_d   = '0;
      sr_d    = '1;
    end else begin
      idx_d   = idx_q + 1'b1;
      sr_d    = {LINE_MARK, sr_q[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      idx_q   <= '0;
      sr_q    <= '1;
    end else if (step_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sr_q    <= sr_d;
    end
  end

  assign busy    = (state_q == SH_SEND);
  assign tx_line = sr_q[0];

  AST_LOAD_DRIVES_START: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (tx_line == LINE_SPACE)); // R6
  AST_IDX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX); // R6
  AST_NO_LOAD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && !busy) |=> !busy); // R8
  AST_IDLE_IS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_line == LINE_MARK)); // R1
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic              bit_tick,
  output logic              tx_ready,
  output logic              tx_line,
  output logic              tx_drained
);
  logic              rst_n_int;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              load;
  logic              busy;

  sertx_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  sertx_hold #(.DATA_W(DATA_W)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tx_enable (tx_enable),
    .load      (load),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  sertx_shift #(.DATA_W(DATA_W)) shift_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bit_tick  (bit_tick),
    .tx_enable (tx_enable),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .load      (load),
    .busy      (busy),
    .tx_line   (tx_line)
  );

  assign tx_ready   = ~hold_full;
  assign tx_drained = ~hold_full & ~busy;

  AST_DRAINED_LINE_MARK: assert property (@(posedge clk) disable iff (!rst_n_int)
    tx_drained |-> tx_line); // R9
endmodule

// File: tb/serial_tx_dbuf_tb_top.sv
module serial_tx_dbuf_tb_top;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_enable = 1'b0;
  logic       bit_tick = 1'b0;
  logic       tx_ready, tx_line, tx_drained;

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0] exp_q[$];
  int frames = 0;
  int burst_n = 0;
  logic chk_gap = 1'b0;

  serial_tx_dbuf dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .bit_tick(bit_tick),
    .tx_ready(tx_ready), .tx_line(tx_line), .tx_drained(tx_drained)
  );

  always #5 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bit-rate tick: one clock high every TICK_DIV clocks, driven after the edge
  initial begin
    forever begin
      for (int i = 0; i < TICK_DIV; i++) begin
        @(posedge clk);
        #1 bit_tick = (i == TICK_DIV - 1);
      end
    end
  end

  // line monitor: samples the current bit in the clock that carries the tick
  int       mon_pos = -1;
  logic [7:0] mon_byte = '0;
  int       gap = 0;
  always @(negedge clk) begin
    if (rst_n && bit_tick) begin
      if (mon_pos < 0) begin
        if (tx_line == 1'b0) mon_pos = 0;
        else gap++;
      end else if (mon_pos < 8) begin
        mon_byte[mon_pos] = tx_line;
        mon_pos++;
      end else begin
        chk(tx_line == 1'b1, "R6 stop bit", tx_line, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected character", mon_byte, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(mon_byte == e, "R6 data bits", mon_byte, e);
        end
        if (chk_gap && burst_n > 0) chk(gap == 0, "R7 idle gap between frames", gap, 0);
        burst_n++;
        frames++;
        gap = 0;
        mon_pos = -1;
      end
    end
  end

  task automatic wait_ready();
    do @(negedge clk); while (!tx_ready);
  endtask

  task automatic drive_write(input logic [7:0] v);
    @(posedge clk);
    #1 wr_en = 1'b1; wr_data = v;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic put_char(input logic [7:0] v);
    wait_ready();
    if (tx_enable) exp_q.push_back(v);
    drive_write(v);
  endtask

  task automatic wait_drained();
    do @(negedge clk); while (!tx_drained);
  endtask

  initial begin
    int f0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);
    chk(tx_drained == 1'b1, "R1 drained after reset", tx_drained, 1);
    chk(tx_line == 1'b1, "R1 line mark after reset", tx_line, 1);

    // R4: write while disabled and idle
    f0 = frames;
    drive_write(8'h5A);
    repeat (20) @(negedge clk);
    chk(tx_ready == 1'b1, "R4 ready unchanged when disabled", tx_ready, 1);
    chk(tx_drained == 1'b1, "R4 drained unchanged when disabled", tx_drained, 1);
    @(posedge clk); #1 tx_enable = 1'b1;
    repeat (30) @(negedge clk);
    chk(tx_drained == 1'b1 && frames == f0, "R4 nothing sent after enable", frames, f0);

    // R2/R5: handoff timing
    do @(negedge clk); while (!bit_tick);
    exp_q.push_back(8'hC3);
    drive_write(8'hC3);
    @(negedge clk);
    chk(tx_ready == 1'b0, "R2 ready cleared by write", tx_ready, 0);
    chk(tx_drained == 1'b0, "R9 drained low with held char", tx_drained, 0);
    while (!bit_tick) begin
      chk(tx_ready == 1'b0, "R5 ready low before load tick", tx_ready, 0);
      @(negedge clk);
    end
    @(negedge clk);
    chk(tx_ready == 1'b1, "R5 ready set at load", tx_ready, 1);
    chk(tx_line == 1'b0, "R5 start bit at load", tx_line, 0);
    wait_drained();
    chk(exp_q.size() == 0, "R6 single frame received", exp_q.size(), 0);

    // sweep of all byte values, back to back, with rejected writes in between
    burst_n = 0; chk_gap = 1'b1;
    for (int v = 0; v < 256; v++) begin
      put_char(8'(v));
      #1 wr_en = 1'b1; wr_data = ~8'(v);   // lands while ready is low (R3)
      @(posedge clk);
      #1 wr_en = 1'b0;
    end
    wait_drained();
    chk_gap = 1'b0;
    chk(exp_q.size() == 0, "R3 all sweep characters seen", exp_q.size(), 0);
    chk(burst_n == 256, "R7 sweep frame count", burst_n, 256);
    chk(tx_drained && tx_line, "R9 drained after sweep", tx_line, 1);

    // R8: disable mid-frame with a second char held
    f0 = frames;
    put_char(8'hA5);
    wait_ready();
    put_char(8'h3C);
    @(posedge clk); #1 tx_enable = 1'b0;
    do @(negedge clk); while (frames == f0);
    repeat (30) @(negedge clk);
    chk(frames == f0 + 1, "R8 current frame completes", frames, f0 + 1);
    chk(tx_line == 1'b1, "R8 no load while disabled", tx_line, 1);
    chk(tx_ready == 1'b0, "R8 held char stays held", tx_ready, 0);
    chk(tx_drained == 1'b0, "R9 not drained while held", tx_drained, 0);
    @(posedge clk); #1 tx_enable = 1'b1;
    wait_drained();
    chk(frames == f0 + 2 && exp_q.size() == 0, "R8 held char sent after enable", frames, f0 + 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule